// File: doc/BRIEF.md
# Synchronous Burst Pseudo-Static RAM Host Controller

This block sits between on-chip logic and a 16-bit burst pseudo-static RAM. A user request names a command (read burst, write burst or configuration write), a word address, a beat count and a byte-lane mask. The controller turns it into the memory pin sequence: chip select, address strobe, a gated memory clock, byte-lane enables, configuration select, write strobe and data bus direction. Write words are pulled from a one-word-at-a-time source. Read words are pushed out with a valid strobe.

Burst accesses are clocked. The controller presents the address across a single rising memory clock edge. It then counts a fixed number of edges of latency. After that it moves one word on every edge where the memory's not-ready feedback is low. Not-ready can stretch the start of a burst, for example when the access collides with an internal refresh, and it can also pause the burst part way through. A watchdog on consecutive not-ready edges abandons a hung burst. Even then, chip select is dropped only once not-ready has cleared.

Configuration writes are unclocked. The address is captured by the memory on the rising edge of the address strobe, and one address bit picks which of two configuration registers is written.

Top module: `psram_burst_ctrl`

## Requirements
- R1: `req_ready` is high only when the controller is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is low in the cycle that follows.
- R2: For a clocked access, `mem_le_n` is low together with `mem_ce_n` across exactly one rising edge of `mem_clk`, and it is high again before the next rising edge.
- R3: `mem_clk` is low whenever `mem_ce_n` is high or `mem_cre` is high. It toggles only during clocked accesses.
- R4: Counting the address edge as edge 0, the first word of a burst moves at rising edge LAT (default 3) at the earliest.
- R5: On each rising `mem_clk` edge at or after edge LAT where `mem_wait` is low, exactly one word moves. Addresses increase by one per word. A read gives `rd_valid` with the word, and a write gives a `wr_take` pulse, until `req_len` words (1 to 16) have moved.
- R6: While `mem_wait` is high, no word moves and the burst pointer holds. `mem_ce_n` never rises in the cycle after one in which `mem_wait` was high during an access.
- R7: A burst is abandoned when `mem_wait` is high on more than TIMEOUT (default 64) consecutive data-phase edges. Exactly TIMEOUT is tolerated. On abandonment, `xfer_err` pulses for one cycle, no further words move, and chip select is held until `mem_wait` is seen low.
- R8: During a burst, `mem_be_n[i]` is low exactly when `req_mask[i]` is set. Lane 0 is bits 7:0 and lane 1 is bits 15:8. Both enables are high while an abandoned burst drains, so no data moves then.
- R9: Command code 2 performs a configuration write. `mem_cre` is high and `mem_clk` stays low. The address is held until `mem_le_n` rises, and `mem_we_n` pulses low after that. The value of address bit 19 selects the register written.
- R10: `mem_dq_oe` changes only in a cycle where `mem_ce_n` is high in both that cycle and the one before. It is high for write bursts only.
- R11: After reset, `mem_ce_n`, `mem_le_n` and `mem_we_n` are high, `mem_clk` and `mem_dq_oe` are low, and `req_ready` is high.
- R12: Command codes: 0 is read burst, 1 is write burst, 2 is configuration write. `mem_we_n` is low for the whole of a write burst and high for the whole of a read burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_cmd | input | 2 | 0 read, 1 write, 2 configuration write |
| req_addr | input | 23 | Word address or configuration value |
| req_len | input | 5 | Beats in burst, 1 to 16 |
| req_mask | input | 2 | Byte-lane enables, bit set = lane used |
| wr_data | input | 16 | Current write word |
| wr_take | output | 1 | Current write word consumed |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 16 | Read word |
| xfer_err | output | 1 | Burst abandoned on not-ready timeout |
| mem_clk | output | 1 | Memory clock |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_le_n | output | 1 | Address strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cre | output | 1 | Configuration register select |
| mem_be_n | output | 2 | Byte-lane enables, active low |
| mem_addr | output | 23 | Memory address |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive data bus toward memory |
| mem_dq_in | input | 16 | Data from memory |
| mem_wait | input | 1 | Memory not ready |

## Verification
The bench drives a behavioural memory that stretches bursts with not-ready, both at the start and part way through. A controller that ignored not-ready would repeat or skip words. One that counted latency one edge short would read the filler value the memory shows before data is valid. The watchdog boundary is tested at 64 and at 65 stalled edges. An off-by-one there would either flag a healthy burst or let a hung one run on. The timed-out write must leave memory untouched, which catches byte enables left on while draining. Configuration writes to both register selects are checked for a quiet memory clock, and for the address being taken on the strobe's rising edge.

// File: rtl/psb_pkg.sv
package psb_pkg;
   typedef enum logic [1:0] {
      CMD_READ  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_CFG   = 2'd2
   } psb_cmd_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ADDR,
      ST_LATN,
      ST_DATA,
      ST_DRAIN,
      ST_ALATCH,
      ST_AHOLD,
      ST_AWE,
      ST_AREL,
      ST_END1,
      ST_END2
   } psb_state_e;
endpackage

// File: rtl/psb_clk_phase.sv
module psb_clk_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mclk,
   output logic rise,
   output logic fall
);
   logic phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phase_q <= 1'b0;
      else if (run) phase_q <= ~phase_q;
      else          phase_q <= 1'b0;
   end

   assign mclk = phase_q;
   assign rise = run & ~phase_q;
   assign fall = run & phase_q;

   // R3: memory clock returns low once the clocked phase ends
   p_clk_parks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> !mclk);
endmodule

// File: rtl/psb_wait_timer.sv
module psb_wait_timer #(
   parameter int TIMEOUT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   input  logic wait_i,
   output logic expired
);
   localparam int CW = $clog2(TIMEOUT + 1);

   if (TIMEOUT < 1) begin : g_bad_timeout
      $error("psb_wait_timer: TIMEOUT must be at least 1");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               run_q <= '0;
      else if (clr)             run_q <= '0;
      else if (step) begin
         if (!wait_i)           run_q <= '0;
         else if (run_q != CW'(TIMEOUT)) run_q <= run_q + CW'(1);
      end
   end

   assign expired = step & wait_i & (run_q == CW'(TIMEOUT));
endmodule

// File: rtl/psb_lane_gate.sv
module psb_lane_gate #(
   parameter int LANES = 2
) (
   input  logic             en,
   input  logic [LANES-1:0] mask,
   output logic [LANES-1:0] be_n
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be_n[i] = ~(en & mask[i]);
   end
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl #(
   parameter int ADDR_W      = 23,
   parameter int DATA_W      = 16,
   parameter int MAX_BURST   = 16,
   parameter int LAT         = 3,
   parameter int TIMEOUT     = 64,
   parameter int ASYNC_CYC   = 2,
   parameter int CFG_SEL_BIT = 19,
   localparam int LANES      = DATA_W / 8,
   localparam int LEN_W      = $clog2(MAX_BURST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [LANES-1:0]  req_mask,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_take,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              xfer_err,
   output logic              mem_clk,
   output logic              mem_ce_n,
   output logic              mem_le_n,
   output logic              mem_we_n,
   output logic              mem_cre,
   output logic [LANES-1:0]  mem_be_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   input  logic              mem_wait
);
   import psb_pkg::*;

   localparam int LCW = $clog2(LAT + 1);
   localparam int ACW = $clog2(ASYNC_CYC + 1);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("psram_burst_ctrl: DATA_W must be a whole number of bytes");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("psram_burst_ctrl: LAT must be at least 1");
   end
   if (ASYNC_CYC < 1) begin : g_bad_async
      $error("psram_burst_ctrl: ASYNC_CYC must be at least 1");
   end
   if (CFG_SEL_BIT >= ADDR_W) begin : g_bad_sel
      $error("psram_burst_ctrl: CFG_SEL_BIT outside address");
   end

   psb_state_e        st_q;
   psb_cmd_e          cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;
   logic [LANES-1:0]  mask_q;
   logic [LCW-1:0]    lat_q;
   logic [ACW-1:0]    ac_q;
   logic              oe_q, done_q, abort_q, ok_q;
   logic              rd_valid_q, wr_take_q, err_q;
   logic [DATA_W-1:0] rd_data_q;

   logic sync_st, async_st, run, clk_rise, clk_fall, expired, lane_en;
   logic ac_last;

   assign sync_st  = (st_q == ST_ADDR) || (st_q == ST_LATN) ||
                     (st_q == ST_DATA) || (st_q == ST_DRAIN);
   assign async_st = (st_q == ST_ALATCH) || (st_q == ST_AHOLD) ||
                     (st_q == ST_AWE) || (st_q == ST_AREL);
   assign run      = sync_st;
   assign ac_last  = (ac_q == ACW'(ASYNC_CYC - 1));

   psb_clk_phase i_phase (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .mclk (mem_clk),
      .rise (clk_rise),
      .fall (clk_fall)
   );

   psb_wait_timer #(.TIMEOUT(TIMEOUT)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (st_q == ST_ADDR),
      .step   (clk_rise && (st_q == ST_DATA) && !abort_q),
      .wait_i (mem_wait),
      .expired(expired)
   );

   assign lane_en = (sync_st && (st_q != ST_DRAIN)) || async_st;

   psb_lane_gate #(.LANES(LANES)) i_lanes (
      .en  (lane_en),
      .mask(async_st ? {LANES{1'b1}} : mask_q),
      .be_n(mem_be_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cmd_q      <= CMD_READ;
         addr_q     <= '0;
         left_q     <= '0;
         mask_q     <= '0;
         lat_q      <= '0;
         ac_q       <= '0;
         oe_q       <= 1'b0;
         done_q     <= 1'b0;
         abort_q    <= 1'b0;
         ok_q       <= 1'b0;
         rd_valid_q <= 1'b0;
         wr_take_q  <= 1'b0;
         err_q      <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= 1'b0;
         wr_take_q  <= 1'b0;
         err_q      <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  cmd_q  <= psb_cmd_e'(req_cmd);
                  addr_q <= req_addr;
                  left_q <= req_len;
                  mask_q <= req_mask;
                  oe_q   <= (req_cmd == CMD_WRITE);
                  st_q   <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               lat_q   <= '0;
               ac_q    <= '0;
               done_q  <= 1'b0;
               abort_q <= 1'b0;
               ok_q    <= 1'b0;
               if (left_q == '0) left_q <= LEN_W'(1);
               st_q <= (cmd_q == CMD_CFG) ? ST_ALATCH : ST_ADDR;
            end
            ST_ADDR: begin
               if (clk_fall) st_q <= (LAT == 1) ? ST_DATA : ST_LATN;
            end
            ST_LATN: begin
               if (clk_rise) lat_q <= lat_q + LCW'(1);
               if (clk_fall && lat_q == LCW'(LAT - 1)) st_q <= ST_DATA;
            end
            ST_DATA: begin
               if (clk_rise) begin
                  if (!mem_wait) begin
                     if (cmd_q == CMD_WRITE) wr_take_q <= 1'b1;
                     else begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= mem_dq_in;
                     end
                     left_q <= left_q - LEN_W'(1);
                     if (left_q == LEN_W'(1)) done_q <= 1'b1;
                  end else if (expired) begin
                     err_q   <= 1'b1;
                     abort_q <= 1'b1;
                  end
               end
               if (clk_fall) begin
                  if (done_q)       st_q <= ST_END1;
                  else if (abort_q) st_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (clk_rise && !mem_wait) ok_q <= 1'b1;
               if (clk_fall && ok_q)      st_q <= ST_END1;
            end
            ST_ALATCH, ST_AHOLD, ST_AWE: begin
               if (ac_last) begin
                  ac_q <= '0;
                  st_q <= (st_q == ST_ALATCH) ? ST_AHOLD :
                          (st_q == ST_AHOLD)  ? ST_AWE : ST_AREL;
               end else begin
                  ac_q <= ac_q + ACW'(1);
               end
            end
            ST_AREL: st_q <= ST_END1;
            ST_END1: st_q <= ST_END2;
            ST_END2: begin
               oe_q <= 1'b0;
               st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (st_q == ST_IDLE);
   assign mem_ce_n   = ~(sync_st | async_st);
   assign mem_le_n   = ~((st_q == ST_ADDR) | (st_q == ST_ALATCH));
   assign mem_we_n   = ~((sync_st & (cmd_q == CMD_WRITE)) | (st_q == ST_AWE));
   assign mem_cre    = async_st;
   assign mem_addr   = addr_q;
   assign mem_dq_out = wr_data;
   assign mem_dq_oe  = oe_q;
   assign wr_take    = wr_take_q;
   assign rd_valid   = rd_valid_q;
   assign rd_data    = rd_data_q;
   assign xfer_err   = err_q;

   // R1: one request at a time
   p_busy_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R2: address strobe spans exactly one memory clock rise
   p_le_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_rise && !mem_le_n) |=> ##1 mem_le_n);

   // R3: memory clock quiet outside clocked accesses
   p_clk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce_n || mem_cre) |-> !mem_clk);

   // R6: chip select held while the memory reports not ready
   p_ce_hold_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !mem_cre && mem_wait) |=> !mem_ce_n);

   // R7: an abandon is flagged while the access is still open
   p_err_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> !mem_ce_n);

   // R10: bus direction switches only with the memory deselected
   p_oe_switch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe != $past(mem_dq_oe)) |-> (mem_ce_n && $past(mem_ce_n)));

   // R5: at most one word moves per memory clock rise
   p_one_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_take));
endmodule

// File: tb/test_psram_burst_ctrl.sv
module test_psram_burst_ctrl;
   localparam int LAT = 3;
   localparam int TO  = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_cmd = 2'd0;
   logic [22:0] req_addr = '0;
   logic [4:0]  req_len = 5'd1;
   logic [1:0]  req_mask = 2'b11;
   logic [15:0] wr_data = '0;
   logic        wr_take, rd_valid, xfer_err;
   logic [15:0] rd_data;
   logic        mem_clk, mem_ce_n, mem_le_n, mem_we_n, mem_cre, mem_dq_oe;
   logic [1:0]  mem_be_n;
   logic [22:0] mem_addr;
   logic [15:0] mem_dq_out, mem_dq_in;
   logic        mem_wait;

   always #5 clk = ~clk;

   psram_burst_ctrl #(.LAT(LAT), .TIMEOUT(TO)) i_psram_burst_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len),
      .req_mask(req_mask), .wr_data(wr_data), .wr_take(wr_take),
      .rd_valid(rd_valid), .rd_data(rd_data), .xfer_err(xfer_err),
      .mem_clk(mem_clk), .mem_ce_n(mem_ce_n), .mem_le_n(mem_le_n),
      .mem_we_n(mem_we_n), .mem_cre(mem_cre), .mem_be_n(mem_be_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural memory
   logic [15:0] mem_arr [0:255];
   logic [15:0] exp_arr [0:255];
   logic [22:0] cfg_reg [0:1];
   logic [22:0] a_lat;
   bit  a_seen = 1'b0;
   int  e = 0, ptr = 0, base = 0, xfers = 0, stall_left = 0;
   int  extra_start = 0, stall_at = -1, stall_len = 0, le_count = 0;
   bit  latched = 1'b0, mwr = 1'b0, sync_seen = 1'b0;

   assign mem_wait  = !mem_ce_n && !mem_cre && latched && (e + 1 >= LAT) && (stall_left > 0);
   assign mem_dq_in = (latched && (e + 1 >= LAT)) ? mem_arr[8'(base + ptr)] : 16'hBAD0;

   always @(posedge mem_clk) begin
      if (!mem_ce_n && !mem_cre) begin
         sync_seen = 1'b1;
         if (!mem_le_n) begin
            le_count++;
            latched = 1'b1; base = int'(mem_addr[7:0]); mwr = !mem_we_n;
            e = 0; ptr = 0; xfers = 0; stall_left = extra_start;
         end else if (latched) begin
            check(mwr == !mem_we_n, "R12 we_n steady", int'(mem_we_n), int'(!mwr));
            e++;
            if (e >= LAT) begin
               if (stall_left > 0) stall_left--;
               else begin
                  if (mwr) begin
                     check(mem_dq_oe, "R10 oe on write word", int'(mem_dq_oe), 1);
                     if (!mem_be_n[0]) mem_arr[8'(base + ptr)][7:0]  = mem_dq_out[7:0];
                     if (!mem_be_n[1]) mem_arr[8'(base + ptr)][15:8] = mem_dq_out[15:8];
                  end else begin
                     check(!mem_dq_oe, "R10 oe off on read", int'(mem_dq_oe), 0);
                  end
                  ptr++; xfers++;
                  if (xfers == stall_at) stall_left = stall_len;
               end
            end
         end
      end
   end

   always @(posedge mem_ce_n) begin
      if (sync_seen) check(le_count == 1, "R2 one latch edge", le_count, 1);
      le_count = 0; latched = 1'b0; sync_seen = 1'b0;
   end

   always @(posedge mem_le_n) begin
      if (!mem_ce_n && mem_cre) begin
         a_lat = mem_addr; a_seen = 1'b1;
         check(!mem_clk, "R9 clock low at strobe", int'(mem_clk), 0);
      end
   end

   always @(posedge mem_we_n) begin
      if (!mem_ce_n && mem_cre) begin
         check(a_seen, "R9 strobe before write", int'(a_seen), 1);
         cfg_reg[a_lat[19]] = a_lat;
         a_seen = 1'b0;
      end
   end

   // per-cycle protocol comparison, stream scoreboards, write feeder
   logic [15:0] wq[$];
   int rd_ptr = 0, rd_seen = 0, wr_taken = 0, err_seen = 0;
   logic p_oe = 1'b0, p_ce_n = 1'b1, p_wait = 1'b0, p_cre = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_ce_n || mem_cre) check(!mem_clk, "R3 clock quiet", int'(mem_clk), 0);
         if (mem_dq_oe != p_oe) check(mem_ce_n && p_ce_n, "R10 oe switch", int'(mem_ce_n), 1);
         if (p_wait && !p_ce_n && !p_cre) check(!mem_ce_n, "R6 ce held", int'(mem_ce_n), 0);
         if (rd_valid) begin
            check(rd_data == exp_arr[8'(rd_ptr)], "R5 read word", int'(rd_data),
                  int'(exp_arr[8'(rd_ptr)]));
            rd_ptr++; rd_seen++;
         end
         if (xfer_err) err_seen++;
         if (wr_take) begin
            if (wq.size() > 0) void'(wq.pop_front());
            wr_taken++;
         end
      end
      wr_data = (wq.size() > 0) ? wq[0] : 16'h0000;
      p_oe = mem_dq_oe; p_ce_n = mem_ce_n; p_wait = mem_wait; p_cre = mem_cre;
   end

   task automatic issue(input logic [1:0] cmd, input logic [22:0] addr,
                        input int len, input logic [1:0] mask);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_cmd = cmd; req_addr = addr; req_len = 5'(len); req_mask = mask;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready, "R1 busy after accept", int'(req_ready), 0);
      while (!req_ready) @(negedge clk);
   endtask

   task automatic wr_burst(input int addr, input int len, input logic [1:0] mask,
                           input bit exp_err);
      int t0 = wr_taken;
      int e0 = err_seen;
      for (int i = 0; i < len; i++) begin
         logic [15:0] d = 16'(16'hA000 + addr * 7 + i * 257);
         wq.push_back(d);
         if (!exp_err) begin
            if (mask[0]) exp_arr[8'(addr + i)][7:0]  = d[7:0];
            if (mask[1]) exp_arr[8'(addr + i)][15:8] = d[15:8];
         end
      end
      issue(2'd1, 23'(addr), len, mask);
      check(wr_taken - t0 == (exp_err ? 0 : len), "R5 write words", wr_taken - t0,
            exp_err ? 0 : len);
      check(err_seen - e0 == (exp_err ? 1 : 0), "R7 write error flag", err_seen - e0,
            exp_err ? 1 : 0);
      wq.delete();
   endtask

   task automatic rd_burst(input int addr, input int len, input bit exp_err);
      int e0 = err_seen;
      rd_ptr = addr; rd_seen = 0;
      issue(2'd0, 23'(addr), len, 2'b11);
      check(rd_seen == (exp_err ? 0 : len), "R5 read words", rd_seen, exp_err ? 0 : len);
      check(err_seen - e0 == (exp_err ? 1 : 0), "R7 read error flag", err_seen - e0,
            exp_err ? 1 : 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem_arr[i] = 16'(16'h1000 + i * 3);
         exp_arr[i] = 16'(16'h1000 + i * 3);
      end
      cfg_reg[0] = '0; cfg_reg[1] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(mem_ce_n && mem_le_n && mem_we_n, "R11 strobes idle",
            int'({mem_ce_n, mem_le_n, mem_we_n}), 7);
      check(!mem_clk && !mem_dq_oe, "R11 clock and oe low", int'({mem_clk, mem_dq_oe}), 0);
      check(req_ready, "R11 ready after reset", int'(req_ready), 1);

      // R4 R5 plain bursts: an early sample would return the filler value
      wr_burst(8, 4, 2'b11, 1'b0);
      rd_burst(8, 4, 1'b0);
      // R8 byte lanes
      wr_burst(20, 1, 2'b01, 1'b0);
      wr_burst(21, 2, 2'b10, 1'b0);
      rd_burst(20, 3, 1'b0);
      // R6 start and mid-burst stalls
      extra_start = 5; stall_at = 2; stall_len = 3;
      rd_burst(8, 4, 1'b0);
      wr_burst(40, 6, 2'b11, 1'b0);
      rd_burst(40, 6, 1'b0);
      extra_start = 0; stall_at = -1; stall_len = 0;
      // R5 longest bursts
      rd_burst(0, 16, 1'b0);
      wr_burst(100, 16, 2'b11, 1'b0);
      rd_burst(100, 16, 1'b0);
      // R7 timeout boundary
      extra_start = TO;
      rd_burst(8, 2, 1'b0);
      extra_start = TO + 1;
      rd_burst(8, 2, 1'b1);
      wr_burst(60, 3, 2'b11, 1'b1);
      extra_start = 0;
      rd_burst(58, 6, 1'b0);    // R7 R8 abandoned write left memory untouched
      // R9 configuration writes
      issue(2'd2, 23'h01_2345 & ~23'(1 << 19), 1, 2'b11);
      check(cfg_reg[0] == (23'h01_2345 & ~23'(1 << 19)), "R9 select 0",
            int'(cfg_reg[0]), int'(23'h01_2345 & ~23'(1 << 19)));
      issue(2'd2, 23'h0A_0042 | 23'(1 << 19), 1, 2'b11);
      check(cfg_reg[1] == (23'h0A_0042 | 23'(1 << 19)), "R9 select 1",
            int'(cfg_reg[1]), int'(23'h0A_0042 | 23'(1 << 19)));
      rd_burst(8, 2, 1'b0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule